// File: doc/BRIEF.md
# I2C EEPROM Write Controller

This block is the target-side front end of a byte-addressed serial EEPROM, limited to the write path. It oversamples the two-wire bus (SCL, SDA) with a faster system clock and finds START and STOP conditions. It checks the device select byte against a fixed type code and three chip-enable pins. It then takes a 16-bit memory address, sent high byte first, and collects data bytes into a page buffer. It acknowledges each accepted byte by enabling an open-drain pull-down on SDA.

Buffered bytes reach the storage array only if the master ends the transfer with a STOP in the bit slot right after an acknowledge. A write-control input that is high at any time between START and the end of the address phase blocks the transfer: data bytes are then refused. A committed write starts a timed internal cycle. During that cycle the block ignores the bus completely. When the cycle ends, the address counter moves to the byte after the last one written. A small register array stands in for the non-volatile cells and has a read port for inspection.

Top module: `eeprom_wr_ctrl`

## Requirements
- R1: After reset, the SDA pull-down is off, busy is low, the address counter is 0 and every storage byte reads 0.
- R2: A select byte whose bits 7..4 are 1010, bits 3..1 equal the chip-enable pins and bit 0 (R/W) is 0 is acknowledged. Any other select byte is not acknowledged, and no byte before the next START is acknowledged.
- R3: After an accepted select byte, both address bytes are acknowledged. The first byte forms address bits 15..8 and the second forms bits 7..0.
- R4: With write control low, every data byte is acknowledged. A STOP right after the acknowledge then stores the byte at the address modulo the array depth.
- R5: If write control is high at any moment from START through the end of the second address byte, the address bytes are still acknowledged, but data bytes are not acknowledged and storage is left unchanged.
- R6: A STOP inside a byte (not in the slot after an acknowledge) aborts the write: storage is unchanged and busy stays low.
- R7: A committed write holds busy high for exactly TW_CYCLES clock cycles. During that time no byte is acknowledged, not even the block's own select code.
- R8: Data bytes are placed at successive offsets within the addressed page of PAGE_SIZE bytes and wrap from the page end to the page start. A later byte for the same offset replaces the earlier one.
- R9: The address counter changes only when the write cycle ends. It then holds the page base plus the offset after the last byte written, modulo the page size.
- R10: A repeated START discards all data buffered since the previous START, so those bytes are never stored.
- R11: A STOP after the address bytes with no data byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| wc_i | input | 1 | Write control; high blocks writes |
| chip_en_i | input | 3 | Chip-enable pins matched against select bits 3..1 |
| busy_o | output | 1 | High during the internal write cycle |
| addr_cnt_o | output | 16 | Internal address counter |
| rd_addr_i | input | MEM_AW | Inspection read address of the storage array |
| rd_data_o | output | 8 | Storage byte at rd_addr_i |

## Verification
The hardest case to reach from the ports is where the STOP falls: the same STOP either commits or discards the buffer, depending only on whether it lands in the clock slot after an acknowledge. The bench drives the bus at bit level. It can stop after any number of bits of a byte, so it places STOPs both in the post-acknowledge slot and in the middle of a byte. It issues a full select byte while the write cycle is still running, to show the block stays silent. It also raises write control only during the high address byte, to show that the block remembers this after the line has dropped again.

// File: rtl/eeprom_wr_pkg.sv
// Shared definitions for the EEPROM write controller.
// Assumes: one write-only protocol engine per device.
package eeprom_wr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_IGNORE
    } eng_state_t;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam int         ADDR_W   = 16;
endpackage

// File: rtl/eeprom_bus_sense.sv
// Brings SCL/SDA into the clk domain and flags bus events.
// Assumes: SCL/SDA are much slower than clk; outputs are one-cycle pulses.
module eeprom_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh, sda_sh;
    logic scl_now, scl_prev, sda_now, sda_prev;

    // Synchronizer chain plus one history stage per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SH_W-2:0], scl_i};
            sda_sh <= {sda_sh[SH_W-2:0], sda_i};
        end
    end

    // Edge and condition decode on the synchronized values.
    always_comb begin
        scl_now    = scl_sh[SH_W-2];
        scl_prev   = scl_sh[SH_W-1];
        sda_now    = sda_sh[SH_W-2];
        sda_prev   = sda_sh[SH_W-1];
        sda_o      = sda_now;
        scl_rise_o = scl_now && !scl_prev;
        scl_fall_o = !scl_now && scl_prev;
        start_o    = scl_now && scl_prev && sda_prev && !sda_now;
        stop_o     = scl_now && scl_prev && !sda_prev && sda_now;
    end
endmodule

// File: rtl/eeprom_wr_engine.sv
// Bit/byte protocol engine: select decode, address capture, data
// acceptance, acknowledge timing and write-protect latching.
// Assumes: event pulses come from eeprom_bus_sense; held idle while busy.
module eeprom_wr_engine
    import eeprom_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wc_i,
    input  logic [2:0]        chip_en_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic              buf_clr_o,
    output logic              buf_wr_o,
    output logic [7:0]        buf_data_o,
    output logic              addr_load_o,
    output logic [ADDR_W-1:0] addr_val_o,
    output logic              commit_o
);
    eng_state_t state;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic [7:0] addr_hi, byte_w;
    logic ack_want, ack_pend, in_ack, post_ack, slot10;
    logic wc_block, wc_now, have_data, sel_ok, shifting;

    // Byte assembly, protect window and commit qualification.
    always_comb begin
        byte_w    = {shreg, sda_i};
        sel_ok    = (byte_w[7:4] == DEV_TYPE) && (byte_w[3:1] == chip_en_i) && !byte_w[0];
        wc_now    = wc_block || (wc_i && (state == ST_DEVSEL || state == ST_ADDR_HI
                                          || state == ST_ADDR_LO));
        shifting  = scl_rise_i && !in_ack && !ack_pend
                    && (state == ST_DEVSEL || state == ST_ADDR_HI
                        || state == ST_ADDR_LO || state == ST_DATA);
        commit_o  = stop_i && !busy_i && state == ST_DATA && slot10 && have_data && !wc_block;
        buf_clr_o = start_i && !busy_i;
    end

    // Protocol sequencing and acknowledge drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  bit_cnt <= '0;  shreg <= '0;  addr_hi <= '0;
            ack_want <= 1'b0;  ack_pend <= 1'b0;  in_ack <= 1'b0;
            post_ack <= 1'b0;  slot10 <= 1'b0;  wc_block <= 1'b0;
            have_data <= 1'b0; sda_oe_o <= 1'b0; buf_wr_o <= 1'b0;
            buf_data_o <= '0;  addr_load_o <= 1'b0; addr_val_o <= '0;
        end else begin
            buf_wr_o    <= 1'b0;
            addr_load_o <= 1'b0;
            if (busy_i) begin
                state <= ST_IDLE;  sda_oe_o <= 1'b0;  ack_pend <= 1'b0;
                in_ack <= 1'b0;    post_ack <= 1'b0;  slot10 <= 1'b0;
            end else if (start_i) begin
                state <= ST_DEVSEL;  bit_cnt <= '0;  ack_pend <= 1'b0;
                in_ack <= 1'b0;      post_ack <= 1'b0; slot10 <= 1'b0;
                sda_oe_o <= 1'b0;    have_data <= 1'b0; wc_block <= wc_i;
            end else if (stop_i) begin
                state <= ST_IDLE;  sda_oe_o <= 1'b0;  ack_pend <= 1'b0;
                in_ack <= 1'b0;    post_ack <= 1'b0;  slot10 <= 1'b0;
            end else begin
                wc_block <= wc_now;
                if (scl_fall_i) begin
                    slot10 <= 1'b0;
                    if (ack_pend) begin
                        sda_oe_o <= ack_want;
                        ack_pend <= 1'b0;
                        in_ack   <= 1'b1;
                    end else if (in_ack) begin
                        sda_oe_o <= 1'b0;
                        in_ack   <= 1'b0;
                        post_ack <= 1'b1;
                    end
                end
                if (scl_rise_i && !in_ack && !ack_pend) begin
                    slot10   <= post_ack;
                    post_ack <= 1'b0;
                end
                if (shifting) begin
                    if (bit_cnt != 3'd7) begin
                        shreg   <= byte_w[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                    end else begin
                        bit_cnt  <= '0;
                        ack_pend <= 1'b1;
                        case (state)
                            ST_DEVSEL: begin
                                if (sel_ok) begin
                                    ack_want <= 1'b1;
                                    state    <= ST_ADDR_HI;
                                end else begin
                                    ack_pend <= 1'b0;
                                    state    <= ST_IGNORE;
                                end
                            end
                            ST_ADDR_HI: begin
                                addr_hi  <= byte_w;
                                ack_want <= 1'b1;
                                state    <= ST_ADDR_LO;
                            end
                            ST_ADDR_LO: begin
                                addr_val_o  <= {addr_hi, byte_w};
                                addr_load_o <= 1'b1;
                                ack_want    <= 1'b1;
                                state       <= ST_DATA;
                            end
                            default: begin
                                ack_want <= !wc_now;
                                if (!wc_now) begin
                                    buf_wr_o   <= 1'b1;
                                    buf_data_o <= byte_w;
                                    have_data  <= 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eeprom_page_store.sv
// Page buffer, stand-in storage array, write-cycle timer and address counter.
// Assumes: PAGE_SIZE is a power of two and MEM_AW exceeds its log2.
module eeprom_page_store #(
    parameter int MEM_AW    = 6,
    parameter int PAGE_SIZE = 16,
    parameter int TW_CYCLES = 400,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr_i,
    input  logic              buf_wr_i,
    input  logic [7:0]        buf_data_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_val_i,
    input  logic              commit_i,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_cnt_o
);
    localparam int PB     = $clog2(PAGE_SIZE);
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int TW_W   = $clog2(TW_CYCLES + 1);
    localparam int BASE_W = ADDR_W - PB;
    localparam int MB_W   = MEM_AW - PB;

    logic [7:0]           pbuf [PAGE_SIZE];
    logic [PAGE_SIZE-1:0] valid;
    logic [BASE_W-1:0]    base;
    logic [PB-1:0]        wptr;
    logic [TW_W-1:0]      timer;
    logic [7:0]           mem [DEPTH];

    // Page pointer and slot-valid tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            base  <= '0;
            wptr  <= '0;
        end else begin
            if (buf_clr_i || commit_i) valid <= '0;
            if (addr_load_i) begin
                base <= addr_val_i[ADDR_W-1:PB];
                wptr <= addr_val_i[PB-1:0];
            end
            if (buf_wr_i) begin
                valid[wptr] <= 1'b1;
                wptr        <= wptr + 1'b1;
            end
        end
    end

    // Page buffer data; contents only matter where valid is set.
    always_ff @(posedge clk) begin
        if (buf_wr_i) pbuf[wptr] <= buf_data_i;
    end

    // Write-cycle timer; the counter advances as the cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer      <= '0;
            addr_cnt_o <= '0;
        end else if (timer != '0) begin
            timer <= timer - 1'b1;
            if (timer == TW_W'(1)) addr_cnt_o <= {base, wptr};
        end else if (commit_i) begin
            timer <= TW_W'(TW_CYCLES);
        end
    end

    // Storage array: copies valid page slots on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit_i && timer == '0) begin
            for (int i = 0; i < PAGE_SIZE; i++) begin
                if (valid[i]) mem[{base[MB_W-1:0], PB'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign busy_o    = (timer != '0);
endmodule

// File: rtl/eeprom_wr_ctrl.sv
// Top: EEPROM write controller (bus sense, protocol engine, page store).
// Assumes: open-drain SDA outside; sda_oe_o high pulls the line low.
module eeprom_wr_ctrl #(
    parameter int MEM_AW      = 6,
    parameter int PAGE_SIZE   = 16,
    parameter int TW_CYCLES   = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wc_i,
    input  logic [2:0]        chip_en_i,
    output logic              busy_o,
    output logic [15:0]       addr_cnt_o,
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    logic        sda_s, scl_rise_w, scl_fall_w, start_w, stop_w;
    logic        buf_clr_w, buf_wr_w, addr_load_w, commit_w;
    logic [7:0]  buf_data_w;
    logic [15:0] addr_val_w;

    eeprom_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(scl_rise_w), .scl_fall_o(scl_fall_w),
        .start_o(start_w), .stop_o(stop_w)
    );

    eeprom_wr_engine u_engine (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_s),
        .scl_rise_i(scl_rise_w), .scl_fall_i(scl_fall_w),
        .start_i(start_w), .stop_i(stop_w), .wc_i(wc_i),
        .chip_en_i(chip_en_i), .busy_i(busy_o), .sda_oe_o(sda_oe_o),
        .buf_clr_o(buf_clr_w), .buf_wr_o(buf_wr_w), .buf_data_o(buf_data_w),
        .addr_load_o(addr_load_w), .addr_val_o(addr_val_w), .commit_o(commit_w)
    );

    eeprom_page_store #(
        .MEM_AW(MEM_AW), .PAGE_SIZE(PAGE_SIZE), .TW_CYCLES(TW_CYCLES), .ADDR_W(16)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr_i(buf_clr_w), .buf_wr_i(buf_wr_w),
        .buf_data_i(buf_data_w), .addr_load_i(addr_load_w), .addr_val_i(addr_val_w),
        .commit_i(commit_w), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .busy_o(busy_o), .addr_cnt_o(addr_cnt_o)
    );
endmodule

// File: rtl/eeprom_wr_ctrl_chk.sv
// Checker for eeprom_wr_ctrl, attached by bind below.
// Assumes: commit and scl_fall are the top's internal nets.
module eeprom_wr_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sda_oe,
    input logic        busy,
    input logic        scl_fall,
    input logic        commit,
    input logic [15:0] addr_cnt
);
    // R7: silent on the bus during the write cycle
    a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);
    // R7: write cycle starts only from a commit
    a_r7_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));
    // R7: no new commit while a cycle runs
    a_r7_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !commit);
    // R2: acknowledge drive starts only after SCL falls
    a_r2_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
    // R9: counter moves only as the write cycle ends
    a_r9_cnt_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_cnt) |-> $fell(busy));
endmodule

bind eeprom_wr_ctrl eeprom_wr_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy_o),
    .scl_fall(scl_fall_w), .commit(commit_w), .addr_cnt(addr_cnt_o)
);

// File: tb/eeprom_wr_ctrl_bench.sv
// Scoreboard bench: bus driver pushes expected acknowledges, monitor compares.
module eeprom_wr_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int Q     = 6;
    localparam int TW    = 400;
    localparam int AW    = 6;

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
    logic [2:0]    chip_en = 3'b101;
    logic [AW-1:0] rd_addr = '0;
    logic sda_oe, busy, sda_line;
    logic [15:0] addr_cnt;
    logic [7:0]  rd_data;

    int checks = 0, failures = 0, busy_cycles = 0;
    bit done = 1'b0;
    bit act_ack;
    bit exp_q[$];
    string tag_q[$];
    event ack_ev;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_wr_ctrl u_eeprom_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .wc_i(wc), .chip_en_i(chip_en), .busy_o(busy),
        .addr_cnt_o(addr_cnt), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    initial forever #(CLK_P/2) clk = ~clk;

    always @(posedge clk) if (busy) busy_cycles <= busy_cycles + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected acknowledge per observed ack slot.
    initial forever begin
        @(ack_ev);
        checks++;
        if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL scoreboard-empty actual=%0d expected=none", act_ack);
        end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act_ack != e) begin
                failures++;
                $display("FAIL %s ack actual=%0d expected=%0d", t, act_ack, e);
            end
        end
    end

    task automatic wq(); #(Q*CLK_P); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
    endtask

    // Driver: sends a byte and queues the acknowledge the requirements predict.
    task automatic send_byte(input logic [7:0] b, input bit exp, input string tag);
        send_bits(b, 8);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        act_ack = sda_oe;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        ->ack_ev;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic wait_idle();
        while (busy) #(CLK_P);
        #(4*CLK_P);
    endtask

    task automatic mem_chk(input string tag, input int a, input int exp);
        rd_addr = AW'(a);
        #(CLK_P);
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000*CLK_P);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int b0;
        #1;
        #(5*CLK_P);
        rst_n = 1'b1;
        #(5*CLK_P);
        // R1: reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 addr_cnt", addr_cnt, 0);
        mem_chk("R1 mem", 5, 0);

        // R4 R3 R2: byte write 0x3C to 0x0005; R7 busy length; R9 counter
        bus_start();
        send_byte(8'hAA, 1, "R2 select");
        send_byte(8'h00, 1, "R3 addr hi");
        send_byte(8'h05, 1, "R3 addr lo");
        send_byte(8'h3C, 1, "R4 data");
        b0 = busy_cycles;
        bus_stop();
        chk("R7 busy raised", busy, 1);
        chk("R9 counter held during cycle", addr_cnt, 0);
        wait_idle();
        chk("R7 busy length", busy_cycles - b0, TW);
        mem_chk("R4 stored", 5, 8'h3C);
        chk("R9 counter", addr_cnt, 16'h0006);

        // R8: wrap within page at 0x001E; R7: own select ignored while busy
        bus_start();
        send_byte(8'hAA, 1, "R2 select");
        send_byte(8'h00, 1, "R3 addr hi");
        send_byte(8'h1E, 1, "R3 addr lo");
        send_byte(8'h11, 1, "R8 d0");
        send_byte(8'h22, 1, "R8 d1");
        send_byte(8'h33, 1, "R8 d2");
        send_byte(8'h44, 1, "R8 d3");
        bus_stop();
        bus_start();
        send_byte(8'hAA, 0, "R7 select while busy");
        bus_stop();
        chk("R7 still busy", busy, 1);
        wait_idle();
        mem_chk("R8 wrap 30", 30, 8'h11);
        mem_chk("R8 wrap 31", 31, 8'h22);
        mem_chk("R8 wrap 16", 16, 8'h33);
        mem_chk("R8 wrap 17", 17, 8'h44);
        mem_chk("R8 page neighbour", 32, 0);
        chk("R9 counter wrap", addr_cnt, 16'h0012);

        // R8: seventeen bytes into page at 0x0020, first slot overwritten
        bus_start();
        send_byte(8'hAA, 1, "R2 select");
        send_byte(8'h00, 1, "R3 addr hi");
        send_byte(8'h20, 1, "R3 addr lo");
        for (int i = 0; i < 17; i++) send_byte(8'h50 + 8'(i), 1, "R8 page data");
        bus_stop();
        wait_idle();
        mem_chk("R8 overwrite 32", 32, 8'h60);
        mem_chk("R8 slot 33", 33, 8'h51);
        mem_chk("R8 slot 47", 47, 8'h5F);
        chk("R9 counter after overflow", addr_cnt, 16'h0021);

        // R5: write control high from before START
        wc = 1'b1;
        bus_start();
        send_byte(8'hAA, 1, "R5 select");
        send_byte(8'h00, 1, "R5 addr hi");
        send_byte(8'h05, 1, "R5 addr lo");
        send_byte(8'h99, 0, "R5 data blocked");
        bus_stop();
        wc = 1'b0;
        #(10*CLK_P);
        chk("R5 no cycle", busy, 0);
        mem_chk("R5 unchanged", 5, 8'h3C);

        // R5: write control pulsed only during the high address byte
        bus_start();
        send_byte(8'hAA, 1, "R5 select");
        wc = 1'b1;
        send_byte(8'h00, 1, "R5 addr hi");
        wc = 1'b0;
        send_byte(8'h05, 1, "R5 addr lo");
        send_byte(8'h98, 0, "R5 data blocked by pulse");
        bus_stop();
        #(10*CLK_P);
        chk("R5 pulse no cycle", busy, 0);
        mem_chk("R5 pulse unchanged", 5, 8'h3C);

        // R2: mismatching select codes
        bus_start();
        send_byte(8'hA2, 0, "R2 wrong chip enable");
        send_byte(8'h00, 0, "R2 ignored byte");
        bus_stop();
        bus_start();
        send_byte(8'hBA, 0, "R2 wrong type");
        bus_stop();
        bus_start();
        send_byte(8'hAB, 0, "R2 read bit set");
        bus_stop();
        #(10*CLK_P);
        chk("R2 no cycle", busy, 0);

        // R6: STOP in the middle of a data byte
        bus_start();
        send_byte(8'hAA, 1, "R6 select");
        send_byte(8'h00, 1, "R6 addr hi");
        send_byte(8'h05, 1, "R6 addr lo");
        send_byte(8'h77, 1, "R6 data");
        send_bits(8'h66, 4);
        bus_stop();
        #(10*CLK_P);
        chk("R6 no cycle", busy, 0);
        mem_chk("R6 unchanged", 5, 8'h3C);

        // R11: STOP right after address, no data
        bus_start();
        send_byte(8'hAA, 1, "R11 select");
        send_byte(8'h00, 1, "R11 addr hi");
        send_byte(8'h07, 1, "R11 addr lo");
        bus_stop();
        #(10*CLK_P);
        chk("R11 no cycle", busy, 0);
        chk("R11 counter unchanged", addr_cnt, 16'h0021);

        // R10: repeated START drops earlier buffered byte
        bus_start();
        send_byte(8'hAA, 1, "R10 select");
        send_byte(8'h00, 1, "R10 addr hi");
        send_byte(8'h08, 1, "R10 addr lo");
        send_byte(8'h5A, 1, "R10 first data");
        bus_start();
        send_byte(8'hAA, 1, "R10 select again");
        send_byte(8'h00, 1, "R10 addr hi");
        send_byte(8'h09, 1, "R10 addr lo");
        send_byte(8'h6B, 1, "R10 second data");
        bus_stop();
        wait_idle();
        mem_chk("R10 discarded", 8, 0);
        mem_chk("R10 stored", 9, 8'h6B);
        chk("R9 counter after restart", addr_cnt, 16'h000A);

        #(5*CLK_P);
        chk("scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule